// File: doc/BRIEF.md
# Multiplexed General-Purpose I/O Port

This block is one 8-bit I/O port placed between a simple register bus and the pad ring. Each pin either belongs to a peripheral, which then supplies the pin's output value and output-enable, or acts as a software pin. A software pin takes its drive level from a data register and its direction from a direction register. The pin inputs are resynchronised to the bus clock. Software reads them back through the data address.

Three byte registers hold the configuration: a routing mask, a level register and a direction register. Two synchronous resets are provided. The cold reset returns the whole port to plain software inputs. The hot reset clears the level and direction registers but leaves the routing mask unchanged, so peripheral pins stay connected through a warm restart.

Top module: `gpio_mux_port`

## Requirements
- R1: A pin whose routing bit is 1 drives `pin_out` from `per_out` and `pin_oe` from `per_oe`, bit for bit.
- R2: A pin whose routing bit is 0 drives `pin_out` from its level bit and `pin_oe` from its direction bit. A direction bit of 1 means output and 0 means input.
- R3: At the clock edge where `cold_rst` is high, the routing, level and direction registers and both synchronizer stages all become 0.
- R4: At the clock edge where `hot_rst` is high and `cold_rst` is low, the level and direction registers and the synchronizers become 0. The routing register keeps its value.
- R5: The address map is: 0 is routing, 1 is level, 2 is direction. Address 3 reads as 0, and a write to address 3 changes no register.
- R6: A read at address 1 returns the `pin_in` value that was sampled two rising edges earlier, through a two-stage synchronizer. The stored level bits do not appear there.
- R7: A read at address 0 or 2 returns the stored routing or direction value. The read data is combinational from `addr`.
- R8: When `wr_en` is high, the addressed register takes `wdata` at the next rising edge. A write is ignored at any edge where either reset is high.
- R9: While a pin belongs to a peripheral, writes to its level and direction bits are stored but do not change `pin_out` or `pin_oe`. They take effect as soon as the routing bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and port clock |
| cold_rst | input | 1 | Synchronous full reset, active high |
| hot_rst | input | 1 | Synchronous reset that keeps the routing register, active high |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| per_out | input | 8 | Peripheral output values |
| per_oe | input | 8 | Peripheral output enables |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Output levels to pads |
| pin_oe | output | 8 | Output enables to pads |

## Verification
Random routing masks mix peripheral and software pins within one byte. This shows whether each pin's multiplexer picks its source independently of its neighbours. Random `pin_in` values that change every cycle tell a correct two-edge synchronizer apart from one that is one stage short or that returns the stored level bits. Directed sequences cover the following cases:
- A hot reset with a non-zero routing mask, to separate hot retention from a cold clear.
- Writes presented during a reset.
- Level and direction writes under a peripheral-owned pin, which must stay hidden until the routing bit is released.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

    localparam int GPIO_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_ROUTE = 2'd0,
        SEL_LEVEL = 2'd1,
        SEL_DIR   = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            2'd0:    s = SEL_ROUTE;
            2'd1:    s = SEL_LEVEL;
            2'd2:    s = SEL_DIR;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;
    logic [1:0]   age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
            age_q    <= 2'd0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
            if (age_q != 2'd2) age_q <= age_q + 2'd1;
        end
    end

    assign sync_out = stage2_q;

    // R6: two edges of latency once both stages are refilled after reset
    a_r6_two_stage: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd2) |-> (sync_out == $past(async_in, 2)));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_mux_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              cold_rst,
    input  logic              hot_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      pin_sync,
    output logic [W-1:0]      route_q,
    output logic [W-1:0]      level_q,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      rdata
);
    reg_sel_e sel;
    logic     wr_ok;

    assign sel   = decode_addr(addr);
    assign wr_ok = wr_en && !cold_rst && !hot_rst;

    // Routing register: cleared only by cold reset
    always_ff @(posedge clk) begin
        if (cold_rst) begin
            route_q <= '0;
        end else if (wr_ok && sel == SEL_ROUTE) begin
            route_q <= wdata;
        end
    end

    // Level and direction: cleared by either reset
    always_ff @(posedge clk) begin
        if (cold_rst || hot_rst) begin
            level_q <= '0;
            dir_q   <= '0;
        end else if (wr_ok) begin
            if (sel == SEL_LEVEL) level_q <= wdata;
            if (sel == SEL_DIR)   dir_q   <= wdata;
        end
    end

    always_comb begin
        case (sel)
            SEL_ROUTE: rdata = route_q;
            SEL_LEVEL: rdata = pin_sync;
            SEL_DIR:   rdata = dir_q;
            default:   rdata = '0;
        endcase
    end

    // R3: cold reset clears everything
    a_r3_cold_clear: assert property (@(posedge clk)
        cold_rst |=> (route_q == '0 && level_q == '0 && dir_q == '0));

    // R4: hot reset keeps routing, clears the rest
    a_r4_hot_keep: assert property (@(posedge clk) disable iff (cold_rst)
        hot_rst |=> (route_q == $past(route_q) && level_q == '0 && dir_q == '0));

    // R8: routing write lands on the next edge
    a_r8_route_write: assert property (@(posedge clk) disable iff (cold_rst || hot_rst)
        (wr_en && addr == 2'd0) |=> (route_q == $past(wdata)));

    // R5: a write to the unused address leaves all registers alone
    a_r5_hole_write: assert property (@(posedge clk) disable iff (cold_rst || hot_rst)
        (wr_en && addr == 2'd3) |=> ($stable(route_q) && $stable(level_q) && $stable(dir_q)));

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
    parameter int W = 8
) (
    input  logic [W-1:0] route,
    input  logic [W-1:0] level,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] per_out,
    input  logic [W-1:0] per_oe,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        always_comb begin
            if (route[i]) begin
                pin_out[i] = per_out[i];
                pin_oe[i]  = per_oe[i];
            end else begin
                pin_out[i] = level[i];
                pin_oe[i]  = dir[i];
            end
        end
    end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
    import gpio_mux_pkg::*;
#(
    parameter int WIDTH = GPIO_W
) (
    input  logic              clk,
    input  logic              cold_rst,
    input  logic              hot_rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  rdata,
    input  logic [WIDTH-1:0]  per_out,
    input  logic [WIDTH-1:0]  per_oe,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe
);
    localparam logic [WIDTH-1:0] ALL_ROUTED = {WIDTH{1'b1}};

    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] route_q;
    logic [WIDTH-1:0] level_q;
    logic [WIDTH-1:0] dir_q;
    logic             sync_rst;

    assign sync_rst = cold_rst | hot_rst;

    gpio_sync #(.W(WIDTH)) u_sync (
        .clk      (clk),
        .rst      (sync_rst),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_regs #(.W(WIDTH)) u_regs (
        .clk      (clk),
        .cold_rst (cold_rst),
        .hot_rst  (hot_rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .pin_sync (pin_sync),
        .route_q  (route_q),
        .level_q  (level_q),
        .dir_q    (dir_q),
        .rdata    (rdata)
    );

    gpio_pin_mux #(.W(WIDTH)) u_mux (
        .route   (route_q),
        .level   (level_q),
        .dir     (dir_q),
        .per_out (per_out),
        .per_oe  (per_oe),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    // R9: with every pin routed out, a direction write is invisible on the pads
    a_r9_gpio_hidden: assert property (@(posedge clk) disable iff (cold_rst || hot_rst)
        (wr_en && addr == 2'd2 && route_q == ALL_ROUTED && $stable(per_oe))
        |=> $stable(pin_oe));

endmodule

// File: tb/sim_gpio_mux_port.sv
module sim_gpio_mux_port;
    logic       clk = 1'b0;
    logic       cold_rst, hot_rst, wr_en;
    logic [1:0] addr;
    logic [7:0] wdata, rdata, per_out, per_oe, pin_in, pin_out, pin_oe;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // bench model
    logic [7:0] m_route = 8'h00, m_level = 8'h00, m_dir = 8'h00;
    logic [7:0] m_s1 = 8'h00, m_s2 = 8'h00;

    always #4 clk = ~clk;  // 125 MHz

    gpio_mux_port u0 (
        .clk(clk), .cold_rst(cold_rst), .hot_rst(hot_rst), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .per_out(per_out),
        .per_oe(per_oe), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [7:0] exp_rdata(input logic [1:0] a);
        case (a)
            2'd0:    return m_route;
            2'd1:    return m_s2;
            2'd2:    return m_dir;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_out();
        return (m_route & per_out) | (~m_route & m_level);
    endfunction

    function automatic logic [7:0] exp_oe();
        return (m_route & per_oe) | (~m_route & m_dir);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic check_all();
        logic [7:0] eo, ee;
        string rq;
        case (addr)
            2'd1:    rq = "R6 level read";
            2'd3:    rq = "R5 hole read";
            default: rq = "R7 reg read";
        endcase
        check(rq, rdata, exp_rdata(addr));
        eo = exp_out();
        ee = exp_oe();
        check((((pin_out ^ eo) & m_route) != 0) ? "R1 pin_out" : "R2 pin_out", pin_out, eo);
        check((((pin_oe ^ ee) & m_route) != 0) ? "R1 pin_oe" : "R2 pin_oe", pin_oe, ee);
    endtask

    // Update the model as the edge does (R3, R4, R8)
    task automatic model_edge();
        if (cold_rst) begin
            m_route = 0; m_level = 0; m_dir = 0; m_s1 = 0; m_s2 = 0;
        end else if (hot_rst) begin
            m_level = 0; m_dir = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            if (wr_en) begin
                case (addr)
                    2'd0: m_route = wdata;
                    2'd1: m_level = wdata;
                    2'd2: m_dir   = wdata;
                    default: ;
                endcase
            end
            m_s2 = m_s1;
            m_s1 = pin_in;
        end
    endtask

    task automatic cyc(input logic c, input logic h, input logic w, input logic [1:0] a,
                       input logic [7:0] d, input logic [7:0] po, input logic [7:0] pe,
                       input logic [7:0] pi);
        @(negedge clk);
        cold_rst = c; hot_rst = h; wr_en = w; addr = a; wdata = d;
        per_out = po; per_oe = pe; pin_in = pi;
        #1;
        check_all();
        @(posedge clk);
        model_edge();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd2718));
        cold_rst = 1; hot_rst = 0; wr_en = 0; addr = 0; wdata = 0;
        per_out = 0; per_oe = 0; pin_in = 0;
        @(posedge clk);
        model_edge();
        // R3 reset state on every address
        for (int a = 0; a < 4; a++) cyc(0, 0, 0, a[1:0], 8'h00, 8'hA5, 8'h3C, 8'h00);

        // R2 software pins, R7 readback
        cyc(0, 0, 1, 2'd2, 8'hF0, 8'h00, 8'h00, 8'h00);
        cyc(0, 0, 1, 2'd1, 8'h9C, 8'h00, 8'h00, 8'h00);
        cyc(0, 0, 0, 2'd2, 8'h00, 8'hFF, 8'hFF, 8'h00);

        // R1 mixed routing, then R9 hidden writes
        cyc(0, 0, 1, 2'd0, 8'h0F, 8'h55, 8'h33, 8'h00);
        cyc(0, 0, 1, 2'd2, 8'h0F, 8'h55, 8'h33, 8'h00);
        cyc(0, 0, 1, 2'd1, 8'h6A, 8'h55, 8'h33, 8'h00);
        cyc(0, 0, 1, 2'd0, 8'h00, 8'h55, 8'h33, 8'h00);  // R9 release
        cyc(0, 0, 0, 2'd1, 8'h00, 8'h55, 8'h33, 8'h00);

        // R6 synchronizer latency with a single step on pin_in
        cyc(0, 0, 0, 2'd1, 8'h00, 8'h00, 8'h00, 8'hC3);
        cyc(0, 0, 0, 2'd1, 8'h00, 8'h00, 8'h00, 8'hC3);
        cyc(0, 0, 0, 2'd1, 8'h00, 8'h00, 8'h00, 8'hC3);

        // R5 write to hole
        cyc(0, 0, 1, 2'd3, 8'hFF, 8'h00, 8'h00, 8'h00);
        for (int a = 0; a < 4; a++) cyc(0, 0, 0, a[1:0], 8'h00, 8'h00, 8'h00, 8'h00);

        // R4 hot reset keeps routing; R8 write during reset ignored
        cyc(0, 0, 1, 2'd0, 8'hA6, 8'h00, 8'h00, 8'h00);
        cyc(0, 1, 1, 2'd0, 8'h11, 8'hFF, 8'h00, 8'hFF);
        cyc(0, 0, 0, 2'd0, 8'h00, 8'hFF, 8'h00, 8'h00);
        cyc(1, 0, 1, 2'd2, 8'hFF, 8'h00, 8'h00, 8'h00);
        cyc(0, 0, 0, 2'd0, 8'h00, 8'h00, 8'h00, 8'h00);
        cyc(0, 0, 0, 2'd2, 8'h00, 8'h00, 8'h00, 8'h00);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic c, h;
            c = ($urandom % 50) == 0;
            h = ($urandom % 30) == 0;
            cyc(c, h, ($urandom % 2) == 1, 2'($urandom), 8'($urandom), 8'($urandom),
                8'($urandom), 8'($urandom));
        end
        finish_run();
    end
endmodule